// File: doc/BRIEF.md
# RAS Error-Cause Latch with Abort Freeze

This block gathers up to 32 error sources into one sticky cause register and decides whether they should stop the surrounding hardware. A source can be a hardware level input, or a software write that injects the same cause. Each latched cause passes through two independent masks:

- The abort mask feeds a single wire-OR abort line.
- The interrupt mask feeds a separate wire-OR interrupt line.

While abort is high, four freeze actions are driven from their programmed target bitmaps: scan dump, clock stop, SRAM write protect and block logic. Each action has one 8-bit bitmap for local targets and one for remote targets. The dump engine and the clock gating cells that consume these bitmaps sit outside the block.

Out of reset every cause is masked from abort, so nothing can freeze until software unmasks it. No register releases the abort directly. It falls only when the causes behind it are cleared through the write-zero-to-clear path, when they are masked again, or when the unit is reset.

Register access uses a plain bus: valid, write, byte address, write data, and combinational read data. The word-aligned register offsets are:

| Offset | Register |
|---|---|
| 0x00 | Cause |
| 0x04 | Cause set |
| 0x08 | Abort mask |
| 0x0C | Interrupt mask |
| 0x10 + 4a | Local bitmap for action a |
| 0x20 + 4a | Remote bitmap for action a |

Top module: `ras_trigger_top`

## Requirements
- R1: `abort_o` equals the OR over all 32 bits of (cause AND NOT abort_mask). The abort mask is read and written at offset 0x08, and a 1 in a mask bit blocks that cause.
- R2: Reset clears the cause register to 0 and sets both the abort mask and the interrupt mask to 0xFFFFFFFF. After reset, `abort_o`, `irq_o` and both freeze buses are 0.
- R3: Writing offset 0x04 sets every cause bit that is written as 1 (write-1-to-set). A cause raised this way drives abort and interrupt exactly like a hardware-raised one.
- R4: `err_i` are level inputs. A source that is high at a clock edge sets its cause bit, and the bit stays set after the source drops. A source that is still high re-sets its bit in the cycle after a clear.
- R5: Writing offset 0x00 clears each cause bit written as 0 and leaves each bit written as 1 unchanged. This is the only way to clear a cause. Writes to the set register, the interrupt mask or the bitmaps never release the abort.
- R6: `frz_local_o` and `frz_remote_o` carry action a at bits [8a+7:8a], with a = 0 for scan dump, 1 for clock stop, 2 for SRAM write protect and 3 for block logic. Each field equals its bitmap ANDed with `abort_o`.
- R7: The bitmaps sit at 0x10+4a (local) and 0x20+4a (remote), in data bits [7:0]. A bitmap write is ignored while `abort_o` is high and takes effect while it is low.
- R8: When a hardware set and a write-zero-to-clear hit the same cause bit in the same cycle, the bit ends up set.
- R9: `irq_o` equals the OR of (cause AND NOT interrupt_mask), with the interrupt mask at offset 0x0C. It does not depend on the abort mask.
- R10: Reads return the live register values. The set register and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| err_i | input | 32 | Hardware error level inputs |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| abort_o | output | 1 | Wire-OR of unmasked causes |
| irq_o | output | 1 | Interrupt, wire-OR through its own mask |
| frz_local_o | output | 32 | Local freeze bitmaps, 8 bits per action |
| frz_remote_o | output | 32 | Remote freeze bitmaps, 8 bits per action |

## Verification
The bench first programs the bitmaps while abort is low. It then tries to overwrite them while abort is high. A design that accepts that write would visibly shift the freeze targets in the middle of a freeze.

It lines up a single-cycle hardware set with a clear of the same bit. A design that lets the clear win would lose the error record, which a held-high source would otherwise hide.

It also tries every register except the cause clear and looks for one that releases the abort. It checks bit 31, software injection and the interrupt path with the abort path masked. A wrong mask polarity, a missing top bit, or a shared mask would each show up as a wrong level on the abort or interrupt pin.

// File: rtl/ras_trig_pkg.sv
package ras_trig_pkg;

    localparam int ADDR_W = 8;
    localparam int N_ACT  = 4;
    localparam int ACT_W  = $clog2(N_ACT);

    typedef enum logic [2:0] {
        SEL_CAUSE,
        SEL_SET,
        SEL_AMASK,
        SEL_IMASK,
        SEL_MAP_LOC,
        SEL_MAP_REM,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [ACT_W-1:0] {
        ACT_SCAN_DUMP,
        ACT_CLK_STOP,
        ACT_SRAM_WP,
        ACT_BLK_LOGIC
    } frz_act_e;

    typedef struct packed {
        reg_sel_e sel;
        frz_act_e act;
    } reg_dec_t;

    // Word-aligned decode: 0x0X control words, 0x1X local maps, 0x2X remote maps.
    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.act = frz_act_e'(a[3:2]);
        d.sel = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[7:4])
                4'h0: begin
                    case (a[3:2])
                        2'd0:    d.sel = SEL_CAUSE;
                        2'd1:    d.sel = SEL_SET;
                        2'd2:    d.sel = SEL_AMASK;
                        default: d.sel = SEL_IMASK;
                    endcase
                end
                4'h1:    d.sel = SEL_MAP_LOC;
                4'h2:    d.sel = SEL_MAP_REM;
                default: d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/ras_cause_bank.sv
module ras_cause_bank #(
    parameter int N_SRC = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_SRC-1:0] hw_set_i,
    input  logic [N_SRC-1:0] sw_set_i,
    input  logic             clr_en_i,
    input  logic [N_SRC-1:0] clr_keep_i,
    output logic [N_SRC-1:0] cause_o
);
    logic [N_SRC-1:0] cause_q;
    logic [N_SRC-1:0] kept;

    // Clear is applied first; any set in the same cycle is ORed on top and wins.
    always_comb begin
        kept = clr_en_i ? (cause_q & clr_keep_i) : cause_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cause_q <= '0;
        else       cause_q <= kept | hw_set_i | sw_set_i;
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/ras_mask_reg.sv
module ras_mask_reg #(
    parameter int         W       = 32,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)     q_o <= RST_VAL;
        else if (we_i) q_o <= wdata_i;
    end
endmodule

// File: rtl/ras_wire_or.sv
module ras_wire_or #(
    parameter int N = 32
) (
    input  logic [N-1:0] vec_i,
    input  logic [N-1:0] block_i,
    output logic         any_o
);
    assign any_o = |(vec_i & ~block_i);
endmodule

// File: rtl/ras_freeze_fan.sv
module ras_freeze_fan
    import ras_trig_pkg::*;
#(
    parameter int TGT_W = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   abort_i,
    input  logic                   wr_en_i,
    input  logic                   wr_remote_i,
    input  logic [ACT_W-1:0]       wr_act_i,
    input  logic [TGT_W-1:0]       wdata_i,
    output logic [N_ACT*TGT_W-1:0] map_loc_o,
    output logic [N_ACT*TGT_W-1:0] map_rem_o,
    output logic [N_ACT*TGT_W-1:0] frz_loc_o,
    output logic [N_ACT*TGT_W-1:0] frz_rem_o
);
    // Bitmaps are frozen while abort is high so targets cannot move mid-freeze.
    logic upd_ok;
    assign upd_ok = wr_en_i && !abort_i;

    for (genvar a = 0; a < N_ACT; a++) begin : g_act
        logic [TGT_W-1:0] loc_q;
        logic [TGT_W-1:0] rem_q;
        logic             hit;

        assign hit = upd_ok && (wr_act_i == ACT_W'(a));

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                loc_q <= '0;
                rem_q <= '0;
            end else if (hit) begin
                if (wr_remote_i) rem_q <= wdata_i;
                else             loc_q <= wdata_i;
            end
        end

        assign map_loc_o[a*TGT_W +: TGT_W] = loc_q;
        assign map_rem_o[a*TGT_W +: TGT_W] = rem_q;
        assign frz_loc_o[a*TGT_W +: TGT_W] = loc_q & {TGT_W{abort_i}};
        assign frz_rem_o[a*TGT_W +: TGT_W] = rem_q & {TGT_W{abort_i}};
    end
endmodule

// File: rtl/ras_trigger_top.sv
module ras_trigger_top
    import ras_trig_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int TGT_W = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [N_SRC-1:0]       err_i,
    input  logic                   reg_valid_i,
    input  logic                   reg_write_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [N_SRC-1:0]       reg_wdata_i,
    output logic [N_SRC-1:0]       reg_rdata_o,
    output logic                   abort_o,
    output logic                   irq_o,
    output logic [N_ACT*TGT_W-1:0] frz_local_o,
    output logic [N_ACT*TGT_W-1:0] frz_remote_o
);
    localparam int MAP_W = N_ACT * TGT_W;

    reg_dec_t         dec;
    logic             wr;
    logic             wr_cause, wr_set, wr_amask, wr_imask, wr_map;
    logic [N_SRC-1:0] sw_set;
    logic [N_SRC-1:0] cause_q;
    logic [N_SRC-1:0] amask_q;
    logic [N_SRC-1:0] imask_q;
    logic [MAP_W-1:0] map_loc, map_rem;

    assign dec      = decode_addr(reg_addr_i);
    assign wr       = reg_valid_i && reg_write_i;
    assign wr_cause = wr && (dec.sel == SEL_CAUSE);
    assign wr_set   = wr && (dec.sel == SEL_SET);
    assign wr_amask = wr && (dec.sel == SEL_AMASK);
    assign wr_imask = wr && (dec.sel == SEL_IMASK);
    assign wr_map   = wr && ((dec.sel == SEL_MAP_LOC) || (dec.sel == SEL_MAP_REM));
    assign sw_set   = wr_set ? reg_wdata_i : '0;

    ras_cause_bank #(.N_SRC(N_SRC)) u_cause (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hw_set_i   (err_i),
        .sw_set_i   (sw_set),
        .clr_en_i   (wr_cause),
        .clr_keep_i (reg_wdata_i),
        .cause_o    (cause_q)
    );

    ras_mask_reg #(.W(N_SRC), .RST_VAL({N_SRC{1'b1}})) u_amask (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (wr_amask),
        .wdata_i (reg_wdata_i),
        .q_o     (amask_q)
    );

    ras_mask_reg #(.W(N_SRC), .RST_VAL({N_SRC{1'b1}})) u_imask (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (wr_imask),
        .wdata_i (reg_wdata_i),
        .q_o     (imask_q)
    );

    ras_wire_or #(.N(N_SRC)) u_abort_or (
        .vec_i   (cause_q),
        .block_i (amask_q),
        .any_o   (abort_o)
    );

    ras_wire_or #(.N(N_SRC)) u_irq_or (
        .vec_i   (cause_q),
        .block_i (imask_q),
        .any_o   (irq_o)
    );

    ras_freeze_fan #(.TGT_W(TGT_W)) u_fan (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .abort_i     (abort_o),
        .wr_en_i     (wr_map),
        .wr_remote_i (dec.sel == SEL_MAP_REM),
        .wr_act_i    (dec.act),
        .wdata_i     (reg_wdata_i[TGT_W-1:0]),
        .map_loc_o   (map_loc),
        .map_rem_o   (map_rem),
        .frz_loc_o   (frz_local_o),
        .frz_rem_o   (frz_remote_o)
    );

    // Combinational read of live state; write-only and unmapped words read zero.
    always_comb begin
        reg_rdata_o = '0;
        case (dec.sel)
            SEL_CAUSE:   reg_rdata_o = cause_q;
            SEL_AMASK:   reg_rdata_o = amask_q;
            SEL_IMASK:   reg_rdata_o = imask_q;
            SEL_MAP_LOC: reg_rdata_o[TGT_W-1:0] = map_loc[int'(dec.act)*TGT_W +: TGT_W];
            SEL_MAP_REM: reg_rdata_o[TGT_W-1:0] = map_rem[int'(dec.act)*TGT_W +: TGT_W];
            default:     reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/ras_trigger_chk.sv
module ras_trigger_chk #(
    parameter int N_SRC = 32,
    parameter int MAP_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [N_SRC-1:0] err_i,
    input logic             reg_valid_i,
    input logic             reg_write_i,
    input logic [7:0]       reg_addr_i,
    input logic             abort_o,
    input logic [MAP_W-1:0] frz_local_o,
    input logic [MAP_W-1:0] frz_remote_o,
    input logic [N_SRC-1:0] cause_q,
    input logic [N_SRC-1:0] amask_q
);
    logic rel_wr;
    assign rel_wr = reg_valid_i && reg_write_i &&
                    ((reg_addr_i == 8'h00) || (reg_addr_i == 8'h08));

    // R2: abort mask comes out of reset fully masked
    assert_mask_reset_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (amask_q == '1));

    // R1: no latched cause means no abort
    assert_no_cause_no_abort_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (cause_q == '0) |-> !abort_o);

    // R4: a high hardware source is latched by the next cycle
    assert_hw_latched_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (|err_i) |=> ((cause_q & $past(err_i)) == $past(err_i)));

    // R5: only a cause clear or mask write can release the abort
    assert_abort_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (abort_o && !rel_wr) |=> abort_o);

    // R6: freeze buses are idle whenever abort is low
    assert_freeze_gated_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !abort_o |-> ((frz_local_o == '0) && (frz_remote_o == '0)));

    // R7: targets stay fixed while abort holds
    assert_map_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(abort_o) && abort_o) |-> ($stable(frz_local_o) && $stable(frz_remote_o)));
endmodule

bind ras_trigger_top ras_trigger_chk #(.N_SRC(N_SRC), .MAP_W(ras_trig_pkg::N_ACT*TGT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .err_i        (err_i),
    .reg_valid_i  (reg_valid_i),
    .reg_write_i  (reg_write_i),
    .reg_addr_i   (reg_addr_i),
    .abort_o      (abort_o),
    .frz_local_o  (frz_local_o),
    .frz_remote_o (frz_remote_o),
    .cause_q      (cause_q),
    .amask_q      (amask_q)
);

// File: tb/sim_ras_trigger_top.sv
module sim_ras_trigger_top;
    localparam int K_RD = 0, K_ABORT = 1, K_IRQ = 2, K_FLOC = 3, K_FREM = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] err = '0;
    logic        valid = 1'b0;
    logic        write = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        abort, irq;
    logic [31:0] floc, frem;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ras_trigger_top u0 (
        .clk_i(clk), .rst_i(rst), .err_i(err),
        .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .abort_o(abort), .irq_o(irq),
        .frz_local_o(floc), .frz_remote_o(frem)
    );

    // Monitor: pops expectations and compares against the live outputs.
    initial begin
        sb_item_t it;
        logic [31:0] act;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = rdata;
                K_ABORT: act = {31'd0, abort};
                K_IRQ:   act = {31'd0, irq};
                K_FLOC:  act = floc;
                default: act = frem;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [31:0] exp, input string tag);
        @(negedge clk);
        sb_q.push_back('{kind, exp, tag});
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        valid = 1'b1; write = 1'b0; addr = a;
        #1;
        sb_q.push_back('{K_RD, exp, tag});
        #1;
        valid = 1'b0;
    endtask

    task automatic pulse_err(input logic [31:0] bits);
        @(negedge clk); err = bits;
        @(negedge clk); err = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R2 reset state
        rd_chk(8'h00, 32'h0, "R2 cause reset");
        rd_chk(8'h08, 32'hFFFF_FFFF, "R2 abort mask reset");
        rd_chk(8'h0C, 32'hFFFF_FFFF, "R2 irq mask reset");
        chk(K_ABORT, 0, "R2 abort reset");
        chk(K_IRQ, 0, "R2 irq reset");
        chk(K_FLOC, 0, "R2 freeze local reset");

        // R4 sticky capture, R2 masked abort
        pulse_err(32'h0000_0008);
        rd_chk(8'h00, 32'h0000_0008, "R4 sticky after source drop");
        chk(K_ABORT, 0, "R2 masked cause no abort");

        // R7 program bitmaps while abort low
        wr(8'h10, 32'h0000_00A5);
        wr(8'h14, 32'h0000_003C);
        wr(8'h28, 32'h0000_0081);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd_chk(8'h10, 32'h0000_00A5, "R7 local map write");
        rd_chk(8'h2C, 32'h0000_00FF, "R7 remote map write");
        chk(K_FLOC, 0, "R6 freeze gated while abort low");

        // R1 unmask -> abort; R6 fan-out
        wr(8'h08, 32'hFFFF_FFF7);
        chk(K_ABORT, 1, "R1 unmasked cause aborts");
        chk(K_FLOC, 32'h0000_3CA5, "R6 local freeze fields");
        chk(K_FREM, 32'hFF81_0000, "R6 remote freeze fields");

        // R7 map write ignored while abort high
        wr(8'h10, 32'h0000_0011);
        rd_chk(8'h10, 32'h0000_00A5, "R7 map write ignored in abort");
        chk(K_FLOC, 32'h0000_3CA5, "R7 freeze unchanged in abort");

        // R5 no other path releases abort
        wr(8'h04, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        chk(K_ABORT, 1, "R5 abort held after other writes");
        rd_chk(8'h00, 32'h0000_0008, "R5 write-one keeps cause");

        // R5 W0C releases abort
        wr(8'h00, 32'hFFFF_FFF7);
        rd_chk(8'h00, 32'h0, "R5 zero clears cause");
        chk(K_ABORT, 0, "R5 abort released by clear");
        chk(K_FLOC, 0, "R6 freeze drops with abort");

        // R7 write accepted once abort low
        wr(8'h10, 32'h0000_0011);
        rd_chk(8'h10, 32'h0000_0011, "R7 map write after abort low");

        // R3 software injection, R10 set reads zero
        wr(8'h04, 32'h1000_0000);
        rd_chk(8'h00, 32'h1000_0000, "R3 software set");
        rd_chk(8'h04, 32'h0, "R10 set register reads zero");
        chk(K_ABORT, 0, "R1 injected cause still masked");
        wr(8'h08, 32'hEFFF_FFFF);
        chk(K_ABORT, 1, "R3 injected cause aborts");
        chk(K_FLOC, 32'h0000_3C11, "R6 freeze with new map");
        wr(8'h00, 32'h0);
        chk(K_ABORT, 0, "R5 clear injected cause");

        // R8 set wins over clear in the same cycle
        @(negedge clk);
        err = 32'h1000_0000;
        valid = 1'b1; write = 1'b1; addr = 8'h00; wdata = 32'hEFFF_FFFF;
        @(negedge clk);
        err = '0; valid = 1'b0; write = 1'b0;
        rd_chk(8'h00, 32'h1000_0000, "R8 set beats clear");
        chk(K_ABORT, 1, "R8 abort from collided set");
        wr(8'h00, 32'h0);

        // R4 held source re-sets after clear
        @(negedge clk); err = 32'h0000_0001;
        wr(8'h00, 32'hFFFF_FFFE);
        rd_chk(8'h00, 32'h0000_0001, "R4 held source re-sets");
        @(negedge clk); err = '0;
        wr(8'h00, 32'h0);
        rd_chk(8'h00, 32'h0, "R4 clear after source drop");

        // R9 interrupt path independent of abort mask
        pulse_err(32'h0000_0020);
        chk(K_IRQ, 0, "R9 irq masked");
        wr(8'h0C, 32'hFFFF_FFDF);
        chk(K_IRQ, 1, "R9 irq unmasked");
        chk(K_ABORT, 0, "R9 abort stays masked");
        wr(8'h00, 32'h0);
        chk(K_IRQ, 0, "R9 irq clears with cause");

        // R1 top bit, R10 unmapped read
        wr(8'h04, 32'h8000_0000);
        wr(8'h08, 32'h7FFF_FFFF);
        chk(K_ABORT, 1, "R1 bit 31 aborts");
        rd_chk(8'h40, 32'h0, "R10 unmapped reads zero");
        rd_chk(8'h08, 32'h7FFF_FFFF, "R10 live mask read");

        wait (sb_q.size() == 0);
        #1;
        done = 1;
        finish_run();
    end
endmodule